// File: doc/BRIEF.md
# Two-stage crosspoint routing control registers

This block keeps the routing state for a crosspoint with eight inputs and four outputs. A host programs it over a parallel bus. The bus carries a 2-bit output address and a 4-bit data word. The low three bits of the word name the input channel for that output. The top bit, when set, switches that output off and leaves it in high impedance.

There are two stages of storage. The first stage is a staging register per output. It accepts a word only while the write strobe and the chip enable are both low. The second stage is a live register per output. It drives the routing outputs and follows the staging stage while the active-low commit strobe is low. So a host can prepare all four outputs while the commit strobe is high, then release the commit strobe and change every output in the same cycle.

A mode input chooses who owns the registers. When it is high, the parallel bus owns them. When it is low, the parallel strobes are ignored, and a serial front end may load all four live registers at once from a 16-bit word. After reset every register holds a word with the disable bit set, so all outputs start switched off. Transparency is modelled with clocked registers that load on each clock edge while their control is active.

Top module: `xbar_route_ctl`

## Requirements
- R1: While rst_n is low at a clock edge, every register loads channel 0 with the disable bit set, so after that edge route_en is 0 and route_sel is 0 for all four outputs.
- R2: When bus_par=1 and both wstb_n and csel_n are 0 at an edge, only the staging register for output out_addr loads wdata. The staging registers for the other three outputs keep their contents.
- R3: When wstb_n=1 or csel_n=1, no staging register changes.
- R4: When bus_par=1 and cmt_n=0 at an edge, every live register loads its staging register's value as it stands after that edge. A write made in the same cycle therefore reaches the outputs one clock later.
- R5: When bus_par=1 and cmt_n=1, route_sel and route_en hold, whatever happens to the staging registers.
- R6: In each 4-bit word, bits [2:0] give the input channel (0 to 7) and bit 3 = 1 disables the output. Output i shows the channel on route_sel[3i+2:3i] and shows route_en[i] = NOT bit 3.
- R7: When bus_par=0, wstb_n, csel_n, cmt_n and out_addr have no effect on the staging registers or the live registers.
- R8: When bus_par=0 and ser_ld=1 at an edge, live register i loads ser_word[4i+3:4i].
- R9: When bus_par=1, ser_ld and ser_word have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_par | input | 1 | 1 = parallel bus owns the registers, 0 = serial load port owns them |
| wstb_n | input | 1 | Write strobe, active low |
| csel_n | input | 1 | Chip enable, active low |
| cmt_n | input | 1 | Commit strobe, active low; live registers follow the staging registers while it is low |
| out_addr | input | 2 | Output whose staging register is written |
| wdata | input | 4 | Data word: bit 3 disables the output, bits [2:0] give the channel |
| ser_ld | input | 1 | Serial load pulse that loads all live registers |
| ser_word | input | 16 | Serial word; nibble i goes to output i |
| route_sel | output | 12 | Channel select per output, 3 bits each, output 0 in the low bits |
| route_en | output | 4 | Output enable per output, 1 = driving |

## Verification
Directed cases come first. One write is staged while the commit strobe is held high, which separates the staging stage from the live stage: the outputs must not move until the commit. Another write is made in the same cycle as a commit, which checks the one-clock pass-through. Writes with only one of the two write enables low, and full strobe activity while the serial port owns the block, must leave both stages untouched. This is shown by a later commit that exposes the staging contents. After that, a seeded random mix of addresses, words, strobes, modes and serial loads is compared each cycle against a two-stage model in the bench. This separates a wrong address decode, leakage between outputs, and a swapped disable polarity.

// File: rtl/xbar_route_pkg.sv
// Package: shared sizes and the reset word for the crosspoint routing
// control registers. Assumes one disable bit sits above the channel select.
package xbar_route_pkg;
    localparam int XB_OUTS   = 4;
    localparam int XB_SEL_W  = 3;
    localparam int XB_WORD_W = XB_SEL_W + 1;
    localparam int XB_ADDR_W = $clog2(XB_OUTS);

    // Word with the disable bit set and channel 0: the power-on state
    function automatic logic [XB_WORD_W-1:0] off_word();
        return {1'b1, {XB_SEL_W{1'b0}}};
    endfunction
endpackage

// File: rtl/xbar_addr_dec.sv
// Module: xbar_addr_dec
// Turns the parallel bus strobes and output address into one staging-register
// load enable per output. Assumes the strobes are already synchronous to clk.
module xbar_addr_dec #(
    parameter int NUM_OUTS = 4,
    parameter int ADDR_W   = $clog2(NUM_OUTS)
) (
    input  logic                bus_par,
    input  logic                wstb_n,
    input  logic                csel_n,
    input  logic [ADDR_W-1:0]   out_addr,
    output logic [NUM_OUTS-1:0] wr_hit
);
    logic wr_open;

    // A write window is open only in parallel mode with both enables low
    always_comb wr_open = bus_par & ~wstb_n & ~csel_n;

    for (genvar i = 0; i < NUM_OUTS; i++) begin : g_hit
        // Select the staging register that out_addr points at
        always_comb wr_hit[i] = wr_open && (out_addr == ADDR_W'(i));
    end
endmodule

// File: rtl/xbar_word_reg.sv
// Module: xbar_word_reg
// A word-wide register with a load enable and a synchronous active-low reset
// to a fixed value. Stands in for one level-sensitive latch of the chain.
module xbar_word_reg #(
    parameter int             WORD_W = 4,
    parameter logic [WORD_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    // Take d on each edge where ld is high; reset wins
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= RST_VAL;
        else if (ld)  q <= d;
    end
endmodule

// File: rtl/xbar_commit_ctl.sv
// Module: xbar_commit_ctl
// Chooses the source that loads the live registers: the parallel commit
// strobe in parallel mode, or the serial load pulse in serial mode.
// Assumes the two sources never compete, because bus_par picks one.
module xbar_commit_ctl (
    input  logic bus_par,
    input  logic cmt_n,
    input  logic ser_ld,
    output logic live_ld,
    output logic from_ser
);
    // Serial load counts only while the serial side owns the block
    always_comb from_ser = ~bus_par & ser_ld;
    // Live registers load on a parallel commit or on a serial load
    always_comb live_ld = (bus_par & ~cmt_n) | from_ser;
endmodule

// File: rtl/xbar_route_ctl.sv
// Module: xbar_route_ctl (top)
// Two-stage routing registers for a crosspoint with NUM_OUTS outputs.
// Stage one holds a staged word per output. Stage two holds the live word
// that drives the routing outputs. The live stage samples the staged value as
// it will be after this edge, so a write made while the commit strobe is low
// passes through in one clock. Assumes all inputs are synchronous to clk.
module xbar_route_ctl
    import xbar_route_pkg::*;
#(
    parameter int NUM_OUTS = XB_OUTS,
    parameter int SEL_W    = XB_SEL_W,
    localparam int WORD_W  = SEL_W + 1,
    localparam int ADDR_W  = $clog2(NUM_OUTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_par,
    input  logic                       wstb_n,
    input  logic                       csel_n,
    input  logic                       cmt_n,
    input  logic [ADDR_W-1:0]          out_addr,
    input  logic [WORD_W-1:0]          wdata,
    input  logic                       ser_ld,
    input  logic [NUM_OUTS*WORD_W-1:0] ser_word,
    output logic [NUM_OUTS*SEL_W-1:0]  route_sel,
    output logic [NUM_OUTS-1:0]        route_en
);
    localparam logic [WORD_W-1:0] RST_WORD = {1'b1, {SEL_W{1'b0}}};

    logic [NUM_OUTS-1:0] wr_hit;
    logic                live_ld;
    logic                from_ser;
    logic [WORD_W-1:0]   stg_q   [NUM_OUTS];
    logic [WORD_W-1:0]   stg_nxt [NUM_OUTS];
    logic [WORD_W-1:0]   live_d  [NUM_OUTS];
    logic [WORD_W-1:0]   live_q  [NUM_OUTS];

    xbar_addr_dec #(.NUM_OUTS(NUM_OUTS), .ADDR_W(ADDR_W)) u_dec (
        .bus_par (bus_par),
        .wstb_n  (wstb_n),
        .csel_n  (csel_n),
        .out_addr(out_addr),
        .wr_hit  (wr_hit)
    );

    xbar_commit_ctl u_cmt (
        .bus_par (bus_par),
        .cmt_n   (cmt_n),
        .ser_ld  (ser_ld),
        .live_ld (live_ld),
        .from_ser(from_ser)
    );

    for (genvar i = 0; i < NUM_OUTS; i++) begin : g_out
        // Staged value after this edge: the new word if addressed, else held
        always_comb stg_nxt[i] = wr_hit[i] ? wdata : stg_q[i];

        // Live register source: serial nibble or the staged value
        always_comb live_d[i] = from_ser ? ser_word[i*WORD_W +: WORD_W] : stg_nxt[i];

        xbar_word_reg #(.WORD_W(WORD_W), .RST_VAL(RST_WORD)) u_stg (
            .clk  (clk),
            .rst_n(rst_n),
            .ld   (wr_hit[i]),
            .d    (wdata),
            .q    (stg_q[i])
        );

        xbar_word_reg #(.WORD_W(WORD_W), .RST_VAL(RST_WORD)) u_live (
            .clk  (clk),
            .rst_n(rst_n),
            .ld   (live_ld),
            .d    (live_d[i]),
            .q    (live_q[i])
        );

        // Split the live word into the channel select and the enable
        always_comb begin
            route_sel[i*SEL_W +: SEL_W] = live_q[i][SEL_W-1:0];
            route_en[i]                 = ~live_q[i][SEL_W];
        end
    end
endmodule

// File: rtl/xbar_route_chk.sv
// Module: xbar_route_chk
// Port-level properties of xbar_route_ctl, attached with bind.
module xbar_route_chk #(
    parameter int NUM_OUTS = 4,
    parameter int SEL_W    = 3,
    localparam int WORD_W  = SEL_W + 1,
    localparam int ADDR_W  = $clog2(NUM_OUTS)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_par,
    input logic                       wstb_n,
    input logic                       csel_n,
    input logic                       cmt_n,
    input logic [ADDR_W-1:0]          out_addr,
    input logic [WORD_W-1:0]          wdata,
    input logic                       ser_ld,
    input logic [NUM_OUTS*WORD_W-1:0] ser_word,
    input logic [NUM_OUTS*SEL_W-1:0]  route_sel,
    input logic [NUM_OUTS-1:0]        route_en
);
    // R5
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_par && cmt_n) |=> ($stable(route_sel) && $stable(route_en)));

    // R7
    ser_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_par && !ser_ld) |=> ($stable(route_sel) && $stable(route_en)));

    // R8
    ser_load_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_par && ser_ld) |=> (route_en[0] == !$past(ser_word[SEL_W])));

    // R8
    ser_load_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_par && ser_ld) |=> (route_sel[SEL_W-1:0] == $past(ser_word[SEL_W-1:0])));

    for (genvar i = 0; i < NUM_OUTS; i++) begin : g_pass
        // R4
        pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_par && !cmt_n && !wstb_n && !csel_n && out_addr == ADDR_W'(i))
            |=> (route_sel[i*SEL_W +: SEL_W] == $past(wdata[SEL_W-1:0])
                 && route_en[i] == !$past(wdata[SEL_W])));
    end
endmodule

bind xbar_route_ctl xbar_route_chk #(.NUM_OUTS(NUM_OUTS), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/xbar_route_ctl_tb.sv
module xbar_route_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_par = 1'b1, wstb_n = 1'b1, csel_n = 1'b1, cmt_n = 1'b1, ser_ld = 1'b0;
    logic [1:0]  out_addr = '0;
    logic [3:0]  wdata = '0;
    logic [15:0] ser_word = '0;
    logic [11:0] route_sel;
    logic [3:0]  route_en;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [3:0] stg_m [4];
    logic [3:0] live_m [4];

    always #2 clk = ~clk;

    xbar_route_ctl u_dut (.*);

    function automatic logic [11:0] exp_sel();
        logic [11:0] v;
        for (int i = 0; i < 4; i++) v[i*3 +: 3] = live_m[i][2:0];
        return v;
    endfunction

    function automatic logic [3:0] exp_en();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = ~live_m[i][3];
        return v;
    endfunction

    task automatic check(string req);
        checks++;
        if (route_sel !== exp_sel() || route_en !== exp_en()) begin
            fails++;
            $display("FAIL %s: sel=%h en=%b expected sel=%h en=%b",
                     req, route_sel, route_en, exp_sel(), exp_en());
        end
    endtask

    // Drive one cycle of inputs, update the model at the edge, sample 1 ns later
    task automatic step(bit p, bit w, bit c, bit m, logic [1:0] a, logic [3:0] d,
                        bit sl, logic [15:0] sw);
        logic [3:0] nx [4];
        @(negedge clk);
        bus_par = p; wstb_n = w; csel_n = c; cmt_n = m; out_addr = a; wdata = d;
        ser_ld = sl; ser_word = sw;
        @(posedge clk);
        for (int i = 0; i < 4; i++)
            nx[i] = (p && !w && !c && a == 2'(i)) ? d : stg_m[i];
        for (int i = 0; i < 4; i++) begin
            if (!p && sl)       live_m[i] = sw[i*4 +: 4];
            else if (p && !m)   live_m[i] = nx[i];
            stg_m[i] = nx[i];
        end
        #1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250));
        for (int i = 0; i < 4; i++) begin stg_m[i] = 4'b1000; live_m[i] = 4'b1000; end
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state");
        @(negedge clk); rst_n = 1'b1;

        // R2/R5: stage a word for output 2 with commit held high, outputs hold
        step(1, 0, 0, 1, 2'd2, 4'b0101, 0, '0);
        check("R5 staged write does not move outputs");
        // R4/R2: commit exposes only output 2
        step(1, 1, 1, 0, 2'd0, 4'b0000, 0, '0);
        check("R2 commit shows only addressed output");
        // R4: write and commit in the same cycle, output 0 channel 7
        step(1, 0, 0, 0, 2'd0, 4'b0111, 0, '0);
        check("R4 same-cycle write passes through");
        // R6: disable bit on output 2
        step(1, 0, 0, 0, 2'd2, 4'b1011, 0, '0);
        check("R6 bit 3 disables output");
        // R3: only one enable low, then commit
        step(1, 0, 1, 1, 2'd1, 4'b0110, 0, '0);
        step(1, 1, 0, 1, 2'd3, 4'b0010, 0, '0);
        step(1, 1, 1, 0, 2'd0, 4'b0000, 0, '0);
        check("R3 writes with an enable high ignored");
        // R7: serial mode ignores parallel strobes, then commit in parallel
        step(0, 0, 0, 0, 2'd1, 4'b0011, 0, '0);
        check("R7 parallel strobes ignored in serial mode");
        step(1, 1, 1, 0, 2'd0, 4'b0000, 0, '0);
        check("R7 staging untouched in serial mode");
        // R8: serial load of all four outputs
        step(0, 1, 1, 1, 2'd0, 4'b0000, 1, 16'h8A53);
        check("R8 serial load sets all outputs");
        // R9: serial load ignored in parallel mode with commit high
        step(1, 1, 1, 1, 2'd0, 4'b0000, 1, 16'h1234);
        check("R9 serial load ignored in parallel mode");
        // R1: reset mid-run returns to all disabled
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        for (int i = 0; i < 4; i++) begin stg_m[i] = 4'b1000; live_m[i] = 4'b1000; end
        check("R1 reset mid-run");
        @(negedge clk); rst_n = 1'b1;

        // Random mix, checked every cycle against the model (R2 R3 R4 R5 R6 R7 R8 R9)
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r = $urandom;
            step(r[0] | r[1], r[2], r[3] & r[4], r[5] | r[6], r[8:7], r[12:9],
                 r[13] & r[14], 16'($urandom));
            check("R4 random two-stage compare");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule